// File: doc/BRIEF.md
# AES XCBC-MAC Authentication Engine

This block computes a 128-bit message authentication code with the XCBC construction over AES-128. A message is fed as 128-bit blocks over a valid/ready stream. One iterative AES-128 encryption datapath, running one round per clock, serves two purposes. It first derives three 128-bit subkeys from the main key. It then runs the CBC chain under the first subkey. The final block of a message is mixed with the second subkey when it is a whole block. A short final block is padded and mixed with the third subkey instead.

Software loads the main key, the optional subkeys, a saved chaining value, a saved bit count and a received MAC through a register-style load port. It then pulses `start` with three option bits. Continuation leaves out the final-block subkey mixing, so the message can be finished later from the saved chaining value. External subkeys skip the derivation. Integrity-check compares the result with the received MAC. The stream accepts a block only while `blk_ready` is high, and `blk_ready` stays low while a block is being encrypted. The sender must hold `blk_valid` and its data until a cycle in which `blk_ready` is high. Loads and `start` take effect only while the engine is idle or holding a result.

Top module: `xcbc_mac_engine`

## Requirements
- R1: With external subkeys off, the engine derives K1, K2 and K3 as the AES-128 encryption under the main key of 16 bytes of 0x01, 0x02 and 0x03 respectively. These values can be read back on `rd_data` with `rd_sel` 0, 1 and 2.
- R2: Each block is XORed with the running chaining value and encrypted under K1. Block byte 0 is bits 127:120. A new message begins from an all-zero chaining value, so a one-block continuation job returns AES_K1(block).
- R3: A final block with `blk_bytes` of 16 (or any value outside 1..15) is XORed with K2 as well as the chaining value before its last encryption.
- R4: A final block with `blk_bytes` n in 1..15 keeps its first n bytes, puts 0x80 in byte n, zeroes the rest, and is XORed with K3 as well as the chaining value.
- R5: With continuation set, the final block gets no K2/K3 mixing and the chaining value and total count are kept. The next job then resumes from them. Loading a chaining value (`ld_sel` 4) or a total count (`ld_sel` 6) also makes the next job resume.
- R6: With external subkeys set, no derivation runs. K1, K2 and K3 come from `ld_sel` 1, 2 and 3 and read back unchanged.
- R7: With integrity-check set, `mac_match` is 1 exactly when the MAC equals the value loaded with `ld_sel` 5. With it clear, `mac_match` is 0.
- R8: `job_bits` counts the bits accepted in the current job and restarts at 0 on each `start`. `total_bits` counts the bits of the whole message. Non-final blocks and full final blocks add 128, and a short final block adds 8·n.
- R9: `blk_ready` is high only while the engine waits for a block. After an accepted block it stays low for exactly 11 cycles.
- R10: `mac_valid` is 0 after reset. Once set, it and `mac` hold until the next accepted `start` or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a job (accepted when idle or done) |
| cfg_cont | input | 1 | Continuation: no final-block subkey mixing |
| cfg_ext_keys | input | 1 | Use loaded K1/K2/K3, skip derivation |
| cfg_icv | input | 1 | Compare result with received MAC |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 3 | 0 key, 1 K1, 2 K2, 3 K3, 4 chain, 5 received MAC, 6 total bits |
| ld_data | input | 128 | Load value |
| rd_sel | input | 2 | 0 K1, 1 K2, 2 K3, 3 chain |
| rd_data | output | 128 | Context readback |
| blk_valid | input | 1 | Block offered |
| blk_ready | output | 1 | Block can be accepted |
| blk_data | input | 128 | Message block, byte 0 in bits 127:120 |
| blk_last | input | 1 | Block ends this job |
| blk_bytes | input | 5 | Valid bytes of a final block |
| mac | output | 128 | Computed MAC / final chaining value |
| mac_valid | output | 1 | Result present |
| mac_match | output | 1 | Result equals received MAC |
| busy | output | 1 | Job in progress |
| job_bits | output | CNT_W | Bits accepted in this job |
| total_bits | output | CNT_W | Bits accepted in this message |

## Verification
The bench sweeps every short-final length from 1 to 15, plus the full block, over one-, two- and three-block messages. An engine that mixed in the wrong subkey, misplaced the 0x80 pad byte or padded full blocks would produce a MAC that differs from the arithmetic reference. A known AES-128 vector fed through a one-block continuation job exposes a broken round, key schedule or chaining start value. The bench also checks a message split across two jobs, and a job resumed from a loaded chaining value and count. A design that cleared context on resume, or mixed a subkey into a continued block, would give the wrong final MAC or total count. Further checks alternate matching and corrupted received MACs, measure the exact ready-low window, and keep a result idle for many cycles to catch a flag or MAC that changes without cause.

// File: rtl/xcbc_pkg.sv
package xcbc_pkg;
  localparam int BLK_W    = 128;
  localparam int NB_BYTES = BLK_W / 8;
  localparam int NR       = 10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DERIVE, ST_DATA, ST_ENC, ST_DONE
  } xcbc_state_e;

  localparam logic [2:0] SEL_KEY   = 3'd0;
  localparam logic [2:0] SEL_K1    = 3'd1;
  localparam logic [2:0] SEL_K2    = 3'd2;
  localparam logic [2:0] SEL_K3    = 3'd3;
  localparam logic [2:0] SEL_CHAIN = 3'd4;
  localparam logic [2:0] SEL_RXMAC = 3'd5;
  localparam logic [2:0] SEL_TOTAL = 3'd6;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] x, p;
    x = a;
    p = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xtime(x);
    end
    return p;
  endfunction

  // substitution: multiplicative inverse as a^254, then the affine map
  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] sq, inv;
    sq  = a;
    inv = 8'h01;
    for (int i = 1; i < 8; i++) begin
      sq  = gf_mul(sq, sq);
      inv = gf_mul(inv, sq);
    end
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
           {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [BLK_W-1:0] sub_bytes(input logic [BLK_W-1:0] s);
    logic [BLK_W-1:0] r;
    for (int i = 0; i < NB_BYTES; i++) r[BLK_W-1-8*i -: 8] = sbox(s[BLK_W-1-8*i -: 8]);
    return r;
  endfunction

  function automatic logic [BLK_W-1:0] shift_rows(input logic [BLK_W-1:0] s);
    logic [BLK_W-1:0] r;
    for (int c = 0; c < 4; c++)
      for (int w = 0; w < 4; w++)
        r[BLK_W-1-8*(4*c+w) -: 8] = s[BLK_W-1-8*(4*((c+w)%4)+w) -: 8];
    return r;
  endfunction

  function automatic logic [BLK_W-1:0] mix_columns(input logic [BLK_W-1:0] s);
    logic [BLK_W-1:0] r;
    logic [7:0] a0, a1, a2, a3;
    for (int c = 0; c < 4; c++) begin
      a0 = s[BLK_W-1-32*c -: 8];
      a1 = s[BLK_W-9-32*c -: 8];
      a2 = s[BLK_W-17-32*c -: 8];
      a3 = s[BLK_W-25-32*c -: 8];
      r[BLK_W-1-32*c -: 8]  = xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3;
      r[BLK_W-9-32*c -: 8]  = a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3;
      r[BLK_W-17-32*c -: 8] = a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3;
      r[BLK_W-25-32*c -: 8] = xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3);
    end
    return r;
  endfunction

  function automatic logic [BLK_W-1:0] key_next(input logic [BLK_W-1:0] rk, input logic [7:0] rc);
    logic [31:0] w0, w1, w2, w3, t;
    w0 = rk[127:96];
    w1 = rk[95:64];
    w2 = rk[63:32];
    w3 = rk[31:0];
    t  = {sbox(w3[23:16]) ^ rc, sbox(w3[15:8]), sbox(w3[7:0]), sbox(w3[31:24])};
    w0 = w0 ^ t;
    w1 = w1 ^ w0;
    w2 = w2 ^ w1;
    w3 = w3 ^ w2;
    return {w0, w1, w2, w3};
  endfunction
endpackage

// File: rtl/xcbc_aes_core.sv
module xcbc_aes_core
  import xcbc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BLK_W-1:0] key_in,
  input  logic [BLK_W-1:0] pt_in,
  output logic             busy,
  output logic             done,
  output logic [BLK_W-1:0] ct_out
);
  localparam int RND_W = $clog2(NR + 1);

  logic [BLK_W-1:0] state_q, rkey_q, rkey_nx, after_sr, after_mix;
  logic [7:0]       rcon_q;
  logic [RND_W-1:0] rnd_q;
  logic             busy_q, done_q, final_rnd;

  assign final_rnd = (rnd_q == RND_W'(NR));
  assign rkey_nx   = key_next(rkey_q, rcon_q);
  assign after_sr  = shift_rows(sub_bytes(state_q));
  assign after_mix = final_rnd ? after_sr : mix_columns(after_sr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= '0;
      rkey_q  <= '0;
      rcon_q  <= 8'h01;
      rnd_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        state_q <= pt_in ^ key_in;
        rkey_q  <= key_in;
        rcon_q  <= 8'h01;
        rnd_q   <= RND_W'(1);
        busy_q  <= 1'b1;
      end else if (busy_q) begin
        state_q <= after_mix ^ rkey_nx;
        rkey_q  <= rkey_nx;
        rcon_q  <= xtime(rcon_q);
        rnd_q   <= rnd_q + RND_W'(1);
        if (final_rnd) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign ct_out = state_q;
endmodule

// File: rtl/xcbc_blk_prep.sv
module xcbc_blk_prep
  import xcbc_pkg::*;
(
  input  logic [BLK_W-1:0] data,
  input  logic [BLK_W-1:0] chain,
  input  logic [BLK_W-1:0] k2,
  input  logic [BLK_W-1:0] k3,
  input  logic [4:0]       nbytes,
  input  logic             last,
  input  logic             cont,
  output logic             short_blk,
  output logic [BLK_W-1:0] mixed
);
  logic [BLK_W-1:0] padded, key_mask;
  logic             closing;

  assign short_blk = last && (nbytes != 5'd0) && (nbytes < 5'(NB_BYTES));
  assign closing   = last && !cont;

  for (genvar g = 0; g < NB_BYTES; g++) begin : g_pad
    always_comb begin
      if (!short_blk || (5'(g) < nbytes))
        padded[BLK_W-1-8*g -: 8] = data[BLK_W-1-8*g -: 8];
      else if (5'(g) == nbytes)
        padded[BLK_W-1-8*g -: 8] = 8'h80;
      else
        padded[BLK_W-1-8*g -: 8] = 8'h00;
    end
  end

  always_comb begin
    if (!closing)       key_mask = '0;
    else if (short_blk) key_mask = k3;
    else                key_mask = k2;
    mixed = padded ^ chain ^ key_mask;
  end
endmodule

// File: rtl/xcbc_mac_engine.sv
module xcbc_mac_engine
  import xcbc_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cfg_cont,
  input  logic             cfg_ext_keys,
  input  logic             cfg_icv,
  input  logic             ld_en,
  input  logic [2:0]       ld_sel,
  input  logic [127:0]     ld_data,
  input  logic [1:0]       rd_sel,
  output logic [127:0]     rd_data,
  input  logic             blk_valid,
  output logic             blk_ready,
  input  logic [127:0]     blk_data,
  input  logic             blk_last,
  input  logic [4:0]       blk_bytes,
  output logic [127:0]     mac,
  output logic             mac_valid,
  output logic             mac_match,
  output logic             busy,
  output logic [CNT_W-1:0] job_bits,
  output logic [CNT_W-1:0] total_bits
);
  localparam logic [CNT_W-1:0] FULL_BITS = CNT_W'(BLK_W);

  xcbc_state_e      st_q;
  logic [BLK_W-1:0] key_q, k1_q, k2_q, k3_q, chain_q, rxmac_q, mac_q;
  logic [CNT_W-1:0] total_q, job_q, add_bits;
  logic             cont_q, icv_q, last_q, open_q, mac_valid_q, match_q;
  logic [1:0]       idx_q;
  logic             can_cfg, start_go, accept, short_blk;
  logic             core_start, core_busy, core_done;
  logic [BLK_W-1:0] core_key, core_pt, core_ct, blk_mixed;
  logic [7:0]       derive_byte;

  assign can_cfg  = (st_q == ST_IDLE) || (st_q == ST_DONE);
  assign start_go = start && can_cfg;
  assign accept   = blk_valid && (st_q == ST_DATA);

  xcbc_blk_prep u_prep (
    .data      (blk_data),
    .chain     (chain_q),
    .k2        (k2_q),
    .k3        (k3_q),
    .nbytes    (blk_bytes),
    .last      (blk_last),
    .cont      (cont_q),
    .short_blk (short_blk),
    .mixed     (blk_mixed)
  );

  assign derive_byte = 8'(idx_q) + 8'd1;
  assign core_start  = ((st_q == ST_DERIVE) && !core_busy && !core_done) || accept;
  assign core_key    = (st_q == ST_DERIVE) ? key_q : k1_q;
  assign core_pt     = (st_q == ST_DERIVE) ? {NB_BYTES{derive_byte}} : blk_mixed;
  assign add_bits    = short_blk ? CNT_W'({blk_bytes, 3'b000}) : FULL_BITS;

  xcbc_aes_core u_aes (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (core_start),
    .key_in (core_key),
    .pt_in  (core_pt),
    .busy   (core_busy),
    .done   (core_done),
    .ct_out (core_ct)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      key_q       <= '0;
      k1_q        <= '0;
      k2_q        <= '0;
      k3_q        <= '0;
      chain_q     <= '0;
      rxmac_q     <= '0;
      mac_q       <= '0;
      total_q     <= '0;
      job_q       <= '0;
      cont_q      <= 1'b0;
      icv_q       <= 1'b0;
      last_q      <= 1'b0;
      open_q      <= 1'b0;
      mac_valid_q <= 1'b0;
      match_q     <= 1'b0;
      idx_q       <= '0;
    end else begin
      if (ld_en && can_cfg) begin
        case (ld_sel)
          SEL_KEY:   key_q   <= ld_data;
          SEL_K1:    k1_q    <= ld_data;
          SEL_K2:    k2_q    <= ld_data;
          SEL_K3:    k3_q    <= ld_data;
          SEL_CHAIN: begin chain_q <= ld_data; open_q <= 1'b1; end
          SEL_RXMAC: rxmac_q <= ld_data;
          SEL_TOTAL: begin total_q <= ld_data[CNT_W-1:0]; open_q <= 1'b1; end
          default:   ;
        endcase
      end
      case (st_q)
        ST_DERIVE: if (core_done) begin
          case (idx_q)
            2'd0:    k1_q <= core_ct;
            2'd1:    k2_q <= core_ct;
            default: k3_q <= core_ct;
          endcase
          if (idx_q == 2'd2) st_q <= ST_DATA;
          idx_q <= idx_q + 2'd1;
        end
        ST_DATA: if (accept) begin
          job_q   <= job_q + add_bits;
          total_q <= total_q + add_bits;
          last_q  <= blk_last;
          st_q    <= ST_ENC;
        end
        ST_ENC: if (core_done) begin
          chain_q <= core_ct;
          if (last_q) begin
            mac_q       <= core_ct;
            mac_valid_q <= 1'b1;
            match_q     <= icv_q && (core_ct == rxmac_q);
            open_q      <= cont_q;
            st_q        <= ST_DONE;
          end else begin
            st_q <= ST_DATA;
          end
        end
        default: ;
      endcase
      if (start_go) begin
        cont_q      <= cfg_cont;
        icv_q       <= cfg_icv;
        job_q       <= '0;
        mac_valid_q <= 1'b0;
        match_q     <= 1'b0;
        idx_q       <= '0;
        st_q        <= cfg_ext_keys ? ST_DATA : ST_DERIVE;
        if (!open_q) begin
          chain_q <= '0;
          total_q <= '0;
        end
      end
    end
  end

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = k1_q;
      2'd1:    rd_data = k2_q;
      2'd2:    rd_data = k3_q;
      default: rd_data = chain_q;
    endcase
  end

  assign blk_ready  = (st_q == ST_DATA);
  assign busy       = !can_cfg;
  assign mac        = mac_q;
  assign mac_valid  = mac_valid_q;
  assign mac_match  = match_q;
  assign job_bits   = job_q;
  assign total_bits = total_q;
endmodule

// File: rtl/xcbc_mac_checker.sv
module xcbc_mac_checker #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             blk_valid,
  input logic             blk_ready,
  input logic             blk_last,
  input logic [127:0]     mac,
  input logic             mac_valid,
  input logic             mac_match,
  input logic [CNT_W-1:0] job_bits
);
  AST_READY_DROPS_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && blk_ready) |=> !blk_ready); // R9
  AST_NO_READY_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    mac_valid |-> !blk_ready); // R9
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_valid && !start) |=> (mac_valid && $stable(mac))); // R10
  AST_START_CLEARS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> !mac_valid); // R10
  AST_MATCH_NEEDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    mac_match |-> mac_valid); // R7
  AST_JOB_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && blk_ready && !blk_last) |=> (job_bits == $past(job_bits) + CNT_W'(128))); // R8
endmodule

bind xcbc_mac_engine xcbc_mac_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .blk_valid (blk_valid),
  .blk_ready (blk_ready),
  .blk_last  (blk_last),
  .mac       (mac),
  .mac_valid (mac_valid),
  .mac_match (mac_match),
  .job_bits  (job_bits)
);

// File: tb/tb_xcbc_mac_engine.sv
`timescale 1ns/1ps
module tb_xcbc_mac_engine;
  localparam int CW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, cfg_cont = 1'b0, cfg_ext_keys = 1'b0, cfg_icv = 1'b0;
  logic ld_en = 1'b0;
  logic [2:0] ld_sel = '0;
  logic [127:0] ld_data = '0;
  logic [1:0] rd_sel = '0;
  logic [127:0] rd_data;
  logic blk_valid = 1'b0, blk_ready, blk_last = 1'b0;
  logic [127:0] blk_data = '0;
  logic [4:0] blk_bytes = '0;
  logic [127:0] mac;
  logic mac_valid, mac_match, busy;
  logic [CW-1:0] job_bits, total_bits;

  always #4 clk = ~clk;

  xcbc_mac_engine #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_cont(cfg_cont),
    .cfg_ext_keys(cfg_ext_keys), .cfg_icv(cfg_icv), .ld_en(ld_en),
    .ld_sel(ld_sel), .ld_data(ld_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_data(blk_data),
    .blk_last(blk_last), .blk_bytes(blk_bytes), .mac(mac),
    .mac_valid(mac_valid), .mac_match(mac_match), .busy(busy),
    .job_bits(job_bits), .total_bits(total_bits)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;
  logic [7:0] sb_t [256];
  logic [127:0] msg [4];

  // ---------------- reference arithmetic ----------------
  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] acc = '0;
    for (int i = 0; i < 8; i++) if (b[i]) acc = acc ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (acc[i]) acc = acc ^ (16'h011b << (i - 8));
    return acc[7:0];
  endfunction

  function automatic logic [127:0] m_aes(input logic [127:0] k, input logic [127:0] p);
    logic [31:0] w [44];
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [7:0] rc, a0, a1, a2, a3;
    logic [31:0] tmp;
    logic [127:0] r;
    for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
    rc = 8'h01;
    for (int i = 4; i < 44; i++) begin
      tmp = w[i-1];
      if (i % 4 == 0) begin
        tmp = {sb_t[tmp[23:16]], sb_t[tmp[15:8]], sb_t[tmp[7:0]], sb_t[tmp[31:24]]} ^ {rc, 24'h0};
        rc = m_mul(rc, 8'h02);
      end
      w[i] = w[i-4] ^ tmp;
    end
    for (int i = 0; i < 16; i++) s[i] = p[127-8*i -: 8] ^ w[i/4][31-8*(i%4) -: 8];
    for (int rd = 1; rd <= 10; rd++) begin
      for (int i = 0; i < 16; i++) t[i] = sb_t[s[i]];
      for (int c = 0; c < 4; c++)
        for (int q = 0; q < 4; q++) s[4*c+q] = t[4*((c+q)%4)+q];
      if (rd < 10)
        for (int c = 0; c < 4; c++) begin
          a0 = s[4*c]; a1 = s[4*c+1]; a2 = s[4*c+2]; a3 = s[4*c+3];
          s[4*c]   = m_mul(a0, 8'd2) ^ m_mul(a1, 8'd3) ^ a2 ^ a3;
          s[4*c+1] = a0 ^ m_mul(a1, 8'd2) ^ m_mul(a2, 8'd3) ^ a3;
          s[4*c+2] = a0 ^ a1 ^ m_mul(a2, 8'd2) ^ m_mul(a3, 8'd3);
          s[4*c+3] = m_mul(a0, 8'd3) ^ a1 ^ a2 ^ m_mul(a3, 8'd2);
        end
      for (int i = 0; i < 16; i++) s[i] = s[i] ^ w[4*rd + i/4][31-8*(i%4) -: 8];
    end
    for (int i = 0; i < 16; i++) r[127-8*i -: 8] = s[i];
    return r;
  endfunction

  function automatic logic [127:0] m_xcbc(input logic [127:0] k1, k2, k3, c0,
                                          input int first, input int nblk, input int lastb,
                                          input bit cont);
    logic [127:0] c, b, mask;
    bit shrt;
    c = c0;
    for (int i = first; i < first + nblk; i++) begin
      b = msg[i];
      if (i == first + nblk - 1) begin
        shrt = (lastb >= 1 && lastb <= 15);
        if (shrt) begin
          mask = ~128'h0 << (8 * (16 - lastb));
          b = (b & mask) | (128'h80 << (8 * (15 - lastb)));
        end
        if (!cont) b = b ^ (shrt ? k3 : k2);
      end
      c = m_aes(k1, b ^ c);
    end
    return c;
  endfunction

  // ---------------- helpers ----------------
  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [2:0] sel, input logic [127:0] d);
    @(negedge clk); ld_en = 1'b1; ld_sel = sel; ld_data = d;
    @(negedge clk); ld_en = 1'b0;
  endtask

  task automatic start_job(input bit cont, input bit ext, input bit icv);
    @(negedge clk); start = 1'b1; cfg_cont = cont; cfg_ext_keys = ext; cfg_icv = icv;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic send(input int i, input bit last, input int nb);
    @(negedge clk);
    blk_valid = 1'b1; blk_data = msg[i]; blk_last = last; blk_bytes = 5'(nb);
    while (!blk_ready) @(negedge clk);
    @(negedge clk);
    blk_valid = 1'b0; blk_last = 1'b0;
  endtask

  task automatic wait_mac();
    int n = 0;
    while (!mac_valid && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 16; j++) msg[i][127-8*j -: 8] = 8'(seed * 7 + 16 * i + j);
  endtask

  function automatic logic [127:0] rd(input logic [1:0] s);
    return 128'h0;
  endfunction

  task automatic read_ctx(input logic [1:0] s, output logic [127:0] v);
    @(negedge clk); rd_sel = s; #1 v = rd_data;
  endtask

  // ---------------- main sequence ----------------
  localparam logic [127:0] KEY  = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] FPT  = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] FCT  = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;

  initial begin
    logic [127:0] dk1, dk2, dk3, exp_mac, mid, v, ek2, ek3, held;
    int lowcnt;
    for (int a = 0; a < 256; a++) begin
      logic [7:0] inv, x;
      inv = 8'h00;
      for (int b = 1; b < 256; b++) if (m_mul(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
      x = inv;
      sb_t[a] = x ^ {x[6:0], x[7]} ^ {x[5:0], x[7:6]} ^ {x[4:0], x[7:5]} ^ {x[3:0], x[7:4]} ^ 8'h63;
    end
    dk1 = m_aes(KEY, {16{8'h01}});
    dk2 = m_aes(KEY, {16{8'h02}});
    dk3 = m_aes(KEY, {16{8'h03}});

    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R10 reset mac_valid", 128'(mac_valid), 128'h0);
    check("R9 reset ready", 128'(blk_ready), 128'h0);
    check("R8 reset counts", {job_bits, total_bits}, 128'h0);

    // known AES vector through a one-block continuation job with loaded K1
    load(3'd1, KEY);
    msg[0] = FPT;
    start_job(1'b1, 1'b1, 1'b0);
    send(0, 1'b1, 16);
    wait_mac();
    check("R2 aes vector via K1 from zero chain", mac, FCT);

    // derived subkeys
    load(3'd0, KEY);
    fill(1);
    start_job(1'b0, 1'b0, 1'b0);
    send(0, 1'b1, 16);
    wait_mac();
    read_ctx(2'd0, v); check("R1 derived K1", v, dk1);
    read_ctx(2'd1, v); check("R1 derived K2", v, dk2);
    read_ctx(2'd2, v); check("R1 derived K3", v, dk3);

    // ready window: two-block continuation job
    fill(2);
    start_job(1'b1, 1'b0, 1'b0);
    send(0, 1'b0, 16);
    lowcnt = 0;
    while (!blk_ready && lowcnt < 100) begin lowcnt++; @(negedge clk); end
    check("R9 ready low cycles after accept", 128'(lowcnt), 128'd11);
    send(1, 1'b1, 16);
    wait_mac();
    check("R5 continuation result unmixed", mac, m_xcbc(dk1, dk2, dk3, '0, 0, 2, 16, 1'b1));
    mid = mac;
    check("R9 no ready while result held", 128'(blk_ready), 128'h0);
    check("R8 total after first part", 128'(total_bits), 128'd256);
    // resume with the kept context
    start_job(1'b0, 1'b1, 1'b0);
    send(2, 1'b1, 16);
    wait_mac();
    exp_mac = m_xcbc(dk1, dk2, dk3, '0, 0, 3, 16, 1'b0);
    check("R5 resumed final MAC", mac, exp_mac);
    check("R8 total after resume", 128'(total_bits), 128'd384);
    check("R8 job bits after resume", 128'(job_bits), 128'd128);
    // resume from a loaded chaining value and count
    load(3'd4, mid);
    load(3'd6, 128'd256);
    start_job(1'b0, 1'b1, 1'b0);
    send(2, 1'b1, 16);
    wait_mac();
    check("R5 resumed from loaded context", mac, exp_mac);
    check("R8 total from loaded count", 128'(total_bits), 128'd384);

    // hold of result
    held = mac;
    repeat (25) @(negedge clk);
    check("R10 result still valid", 128'(mac_valid), 128'h1);
    check("R10 mac unchanged", mac, held);

    // sweep: 1..3 blocks, final length 1..16, match alternating
    for (int nb = 1; nb <= 3; nb++) begin
      for (int lb = 1; lb <= 16; lb++) begin
        bit icv, good;
        string rq;
        fill(nb * 17 + lb);
        exp_mac = m_xcbc(dk1, dk2, dk3, '0, 0, nb, lb, 1'b0);
        icv  = (lb % 2 == 1);
        good = (lb % 4 == 1);
        load(3'd5, good ? exp_mac : (exp_mac ^ 128'h1));
        start_job(1'b0, (lb % 3 == 0), icv);
        for (int i = 0; i < nb; i++) send(i, (i == nb - 1), (i == nb - 1) ? lb : 16);
        wait_mac();
        rq = (lb == 16) ? "R3 full final K2" : "R4 short final K3 pad";
        if (nb > 1) rq = {rq, " R2 chain"};
        check(rq, mac, exp_mac);
        check("R7 match flag", 128'(mac_match), 128'(icv && good));
        check("R8 job bits", 128'(job_bits), 128'((nb - 1) * 128 + (lb == 16 ? 128 : lb * 8)));
        check("R8 total bits new message", 128'(total_bits), 128'(job_bits));
      end
    end

    // external subkeys
    ek2 = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
    ek3 = 128'hdeadbeef0123456789abcdeffedcba98;
    load(3'd1, KEY ^ 128'h55);
    load(3'd2, ek2);
    load(3'd3, ek3);
    fill(99);
    start_job(1'b0, 1'b1, 1'b0);
    send(0, 1'b0, 16);
    send(1, 1'b1, 5);
    wait_mac();
    check("R6 external subkeys short", mac, m_xcbc(KEY ^ 128'h55, ek2, ek3, '0, 0, 2, 5, 1'b0));
    read_ctx(2'd1, v); check("R6 loaded K2 kept", v, ek2);
    read_ctx(2'd2, v); check("R6 loaded K3 kept", v, ek3);
    start_job(1'b0, 1'b1, 1'b0);
    send(2, 1'b1, 16);
    wait_mac();
    check("R6 external subkeys full", mac, m_xcbc(KEY ^ 128'h55, ek2, ek3, '0, 2, 1, 16, 1'b0));
    check("R7 match zero when check off", 128'(mac_match), 128'h0);

    // start clears result
    start_job(1'b0, 1'b1, 1'b0);
    check("R10 start clears valid", 128'(mac_valid), 128'h0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R9 actual=hung expected=progress");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule